// File: doc/BRIEF.md
# Video Output Formatter with Companion Clock Driver

This block sits at the last stage of a video datapath. It registers pixel data one clock after capture so the data leaves the chip with a fixed relationship to its clock. When the limiter is armed and the valid flag is high, it can pull the two extreme code values of every byte lane one step inward. The all-zeros code becomes 01h and the all-ones code becomes FEh. Blanking and sync bytes, which arrive with the valid flag low, always pass through unmodified.

The block also drives a clock for downstream devices that latch the formatted data, together with an output-enable for the clock pad. Software configures it through a small write-only register port sampled on the input clock. Reset leaves the clock pad undriven and the limiter off. In normal operation the pad carries the input clock, with optional inversion. With the test bit set, a source select can route a pixel-rate clock instead. That clock equals the input clock in 16-bit mode and is the input clock halved in the two byte-serial modes.

Top module: `vid_out_fmt`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), pix_out is 0, clk_out_oe is 0 and all control bits are 0.
- R2: With the limiter bit set and valid high, each byte lane of the registered output maps 00h to 01h and FFh to FEh. Every other value is unchanged. Each lane is handled on its own.
- R3: With the limiter bit clear, every byte value passes unchanged, whatever the valid flag is.
- R4: With valid low, data passes unchanged even when the limiter bit is set.
- R5: pix_out reflects the pix_in, valid and limiter state sampled at the preceding rising edge of clk_in, which gives one cycle of latency.
- R6: Register map. Address 40h bit 6 is the limiter. Address 60h holds four clock bits: bit 7 is the output enable, bit 6 is the source select, bit 5 is the inversion and bit 4 is the test bit. Writes to any other address change nothing.
- R7: clk_out_oe equals the output-enable bit. While it is 0, the pad is high-impedance whatever the other clock bits are.
- R8: With the test bit 0, clk_out is clk_in XOR the inversion bit, whatever the source select is.
- R9: With the test bit 1 and the source select 1, clk_out is clk_in XOR the inversion bit.
- R10: With the test bit 1 and the source select 0, clk_out is the pixel clock XOR the inversion bit. In mode 0 (16-bit) the pixel clock is clk_in. In modes 1 (8-bit), 2 (embedded-sync) and 3 (treated as byte-serial) it is a divider flop. That flop is reset to 0 and toggles on every rising edge of clk_in, so it is 1 during the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 = 16-bit, 1 = 8-bit, 2 = embedded-sync byte mode, 3 = byte-serial |
| valid | input | 1 | High during the valid data period |
| pix_in | input | 16 | Pixel data, two byte lanes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| pix_out | output | 16 | Registered, optionally range-limited data |
| clk_out | output | 1 | Companion output clock value |
| clk_out_oe | output | 1 | Output enable for the clock pad |

## Verification
A wrong limiter bit or lane decode shows up at pix_out one cycle after the offending byte. The full byte sweep, run with both limiter settings and both valid levels, drives 00h and FFh through each lane. A stuck or mis-decoded clock control bit shows up within half a clock period on clk_out or clk_out_oe, because the pad is sampled in both clock phases after every configuration write. A divider that has lost phase shows up on the very next high or low sample in a byte-serial mode.

// File: rtl/vof_pkg.sv
package vof_pkg;

   typedef enum logic [1:0] {
      MODE_WIDE  = 2'd0,
      MODE_BYTE  = 2'd1,
      MODE_EMBED = 2'd2,
      MODE_RSVD  = 2'd3
   } vof_mode_e;

   typedef struct packed {
      logic lim;
      logic ck_en;
      logic ck_sel;
      logic ck_inv;
      logic test;
   } vof_cfg_t;

endpackage

// File: rtl/vof_regs.sv
module vof_regs
   import vof_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] A_LIM = 'h40,
   parameter logic [ADDR_W-1:0] A_CLK = 'h60,
   parameter int LIM_BIT  = 6,
   parameter int EN_BIT   = 7,
   parameter int SEL_BIT  = 6,
   parameter int INV_BIT  = 5,
   parameter int TEST_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output vof_cfg_t          cfg
);

   localparam int MAX_BIT = DATA_W - 1;

   if (LIM_BIT > MAX_BIT || EN_BIT > MAX_BIT || SEL_BIT > MAX_BIT ||
       INV_BIT > MAX_BIT || TEST_BIT > MAX_BIT) begin : g_bad_bit
      $error("vof_regs: control bit index beyond data width");
   end
   if (A_LIM == A_CLK) begin : g_bad_addr
      $error("vof_regs: register addresses collide");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         if (addr == A_LIM) begin
            cfg.lim <= wdata[LIM_BIT];
         end
         if (addr == A_CLK) begin
            cfg.ck_en  <= wdata[EN_BIT];
            cfg.ck_sel <= wdata[SEL_BIT];
            cfg.ck_inv <= wdata[INV_BIT];
            cfg.test   <= wdata[TEST_BIT];
         end
      end
   end

   // R6: unmapped addresses leave the configuration untouched
   a_r6_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr != A_LIM && addr != A_CLK) |=> (cfg == $past(cfg)));

   // R6: a limiter write lands in the limiter bit
   a_r6_lim_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_LIM) |=> (cfg.lim == $past(wdata[LIM_BIT])));

endmodule

// File: rtl/vof_clamp.sv
module vof_clamp #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid,
   input  logic                    lim,
   input  logic [LANES*BYTE_W-1:0] din,
   output logic [LANES*BYTE_W-1:0] dout
);

   localparam int          BUS_W  = LANES * BYTE_W;
   localparam logic [BYTE_W-1:0] CODE_LO = '0;
   localparam logic [BYTE_W-1:0] CODE_HI = '1;

   if (LANES < 1 || BYTE_W < 2) begin : g_bad_cfg
      $error("vof_clamp: need at least one lane of two or more bits");
   end

   logic [BUS_W-1:0] nxt;
   logic             arm;

   assign arm = valid & lim;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] b;
      assign b = din[g*BYTE_W +: BYTE_W];
      always_comb begin
         nxt[g*BYTE_W +: BYTE_W] = b;
         if (arm && b == CODE_LO) nxt[g*BYTE_W +: BYTE_W] = CODE_LO + 1'b1;
         if (arm && b == CODE_HI) nxt[g*BYTE_W +: BYTE_W] = CODE_HI - 1'b1;
      end

      // R2: no lane carries a reserved extreme after an armed cycle
      a_r2_no_extremes: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && lim) |=> (dout[g*BYTE_W +: BYTE_W] != CODE_LO &&
                             dout[g*BYTE_W +: BYTE_W] != CODE_HI));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= '0;
      else        dout <= nxt;
   end

   // R4: outside the valid period data is untouched
   a_r4_blank_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> (dout == $past(din)));

   // R3: limiter off means transparent
   a_r3_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !lim |=> (dout == $past(din)));

endmodule

// File: rtl/vof_clkgen.sv
module vof_clkgen
   import vof_pkg::*;
#(
   parameter bit HAS_TEST_SEL = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  vof_mode_e mode,
   input  vof_cfg_t  cfg,
   output logic      clk_out,
   output logic      clk_oe
);

   logic div_q;
   logic pix_clk;
   logic use_pix;
   logic src;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= 1'b0;
      else        div_q <= ~div_q;
   end

   assign pix_clk = (mode == MODE_WIDE) ? clk : div_q;

   if (HAS_TEST_SEL) begin : g_test_sel
      assign use_pix = cfg.test & ~cfg.ck_sel;
   end else begin : g_fixed_src
      assign use_pix = 1'b0;
   end

   assign src     = use_pix ? pix_clk : clk;
   assign clk_out = src ^ cfg.ck_inv;
   assign clk_oe  = cfg.ck_en;

   // R10: divider alternates every edge
   a_r10_div_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !div_q |=> div_q);
   a_r10_div_fall: assert property (@(posedge clk) disable iff (!rst_n)
      div_q |=> !div_q);

endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
   import vof_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] A_LIM = 'h40,
   parameter logic [ADDR_W-1:0] A_CLK = 'h60,
   parameter bit HAS_TEST_SEL = 1'b1
) (
   input  logic                    clk_in,
   input  logic                    rst_n,
   input  logic [1:0]              mode,
   input  logic                    valid,
   input  logic [LANES*BYTE_W-1:0] pix_in,
   input  logic                    reg_we,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [BYTE_W-1:0]       reg_wdata,
   output logic [LANES*BYTE_W-1:0] pix_out,
   output logic                    clk_out,
   output logic                    clk_out_oe
);

   localparam int EN_BIT = 7;

   vof_cfg_t  cfg;
   vof_mode_e mode_e;

   assign mode_e = vof_mode_e'(mode);

   vof_regs #(
      .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .A_LIM(A_LIM), .A_CLK(A_CLK),
      .EN_BIT(EN_BIT)
   ) u_regs (
      .clk(clk_in), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .cfg(cfg)
   );

   vof_clamp #(.LANES(LANES), .BYTE_W(BYTE_W)) u_clamp (
      .clk(clk_in), .rst_n(rst_n), .valid(valid), .lim(cfg.lim),
      .din(pix_in), .dout(pix_out)
   );

   vof_clkgen #(.HAS_TEST_SEL(HAS_TEST_SEL)) u_clkgen (
      .clk(clk_in), .rst_n(rst_n), .mode(mode_e), .cfg(cfg),
      .clk_out(clk_out), .clk_oe(clk_out_oe)
   );

   // R7: a clock-register write with enable 0 floats the pad next cycle
   a_r7_disable_floats: assert property (@(posedge clk_in) disable iff (!rst_n)
      (reg_we && reg_addr == A_CLK && !reg_wdata[EN_BIT]) |=> !clk_out_oe);

   // R7: a clock-register write with enable 1 drives the pad next cycle
   a_r7_enable_drives: assert property (@(posedge clk_in) disable iff (!rst_n)
      (reg_we && reg_addr == A_CLK && reg_wdata[EN_BIT]) |=> clk_out_oe);

endmodule

// File: tb/vid_out_fmt_tb.sv
module vid_out_fmt_tb;

   logic        clk_in = 1'b0;
   logic        rst_n  = 1'b0;
   logic [1:0]  mode   = 2'd0;
   logic        valid  = 1'b0;
   logic [15:0] pix_in = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr  = '0;
   logic [7:0]  reg_wdata = '0;
   logic [15:0] pix_out;
   logic        clk_out;
   logic        clk_out_oe;

   int vectors = 0;
   int errors  = 0;
   bit m_div   = 1'b0;
   bit m_lim   = 1'b0;

   always #5 clk_in = ~clk_in;

   // pixel clock model: cleared in reset, flips every edge after
   always @(posedge clk_in) m_div <= rst_n ? ~m_div : 1'b0;

   vid_out_fmt u_dut (
      .clk_in(clk_in), .rst_n(rst_n), .mode(mode), .valid(valid),
      .pix_in(pix_in), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .pix_out(pix_out), .clk_out(clk_out),
      .clk_out_oe(clk_out_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk_in);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk_in);
      reg_we = 1'b0;
      if (a == 8'h40) m_lim = d[6];
   endtask

   function automatic logic [7:0] lane_exp(input logic [7:0] b, input bit arm);
      if (arm && b == 8'h00) return 8'h01;
      if (arm && b == 8'hFF) return 8'hFE;
      return b;
   endfunction

   task automatic sweep(input bit v);
      for (int i = 0; i < 256; i++) begin
         logic [15:0] d;
         d = {8'(255 - i), 8'(i)};
         @(negedge clk_in);
         valid = v; pix_in = d;
         @(negedge clk_in);
         chk(m_lim ? (v ? "R2/R5" : "R4") : "R3", pix_out,
             {lane_exp(d[15:8], v && m_lim), lane_exp(d[7:0], v && m_lim)});
      end
   endtask

   task automatic clk_case(input logic [1:0] md, input bit en, input bit sel,
                           input bit inv, input bit tst);
      @(negedge clk_in);
      mode = md;
      wr(8'h60, {en, sel, inv, tst, 4'h0});
      for (int c = 0; c < 3; c++) begin
         for (int ph = 0; ph < 2; ph++) begin
            bit lvl;
            bit src;
            if (ph == 0) @(posedge clk_in); else @(negedge clk_in);
            #2;
            lvl = (ph == 0);
            chk("R7", {15'd0, clk_out_oe}, {15'd0, en});
            if (en) begin
               if (tst && !sel) src = (md == 2'd0) ? lvl : m_div;
               else             src = lvl;
               chk(tst ? (sel ? "R9" : "R10") : "R8", {15'd0, clk_out},
                   {15'd0, src ^ inv});
            end
         end
      end
   endtask

   initial begin : watchdog
      #1500000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_in);
      // R1: reset state
      chk("R1", pix_out, 16'h0000);
      chk("R1", {15'd0, clk_out_oe}, 16'h0000);
      rst_n = 1'b1;

      // R3 after reset: limiter defaults off
      sweep(1'b1);
      sweep(1'b0);

      wr(8'h40, 8'h40);
      sweep(1'b1);
      sweep(1'b0);

      // R6: unmapped addresses must change nothing
      wr(8'h40, 8'h00);
      wr(8'h41, 8'hFF);
      wr(8'h61, 8'hFF);
      @(negedge clk_in);
      chk("R6", {15'd0, clk_out_oe}, 16'h0000);
      @(negedge clk_in); valid = 1'b1; pix_in = 16'hFF00;
      @(negedge clk_in);
      chk("R6", pix_out, 16'hFF00);
      wr(8'h40, 8'hBF);
      @(negedge clk_in); pix_in = 16'h00FF;
      @(negedge clk_in);
      chk("R6", pix_out, 16'h00FF);

      for (int md = 0; md < 4; md++)
         for (int k = 0; k < 16; k++)
            clk_case(2'(md), k[3], k[2], k[1], k[0]);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule